// File: doc/BRIEF.md
# Buffered Input Capture Unit

This block time-stamps pin activity. A free-running main counter runs inside the block. On each qualified edge of one of its input pins, the block copies the counter into that channel's capture register. Each channel also has an edge counter (the pulse accumulator) that counts the same qualified edges. A holding register sits behind each capture register and each accumulator. Software can therefore read an older value while new edges keep arriving.

The holding registers work only while the buffer enable is set. Buffering then runs in one of two modes:

- **Queue mode:** each channel acts as a two-deep queue. A new capture pushes the previous capture into the holding register.
- **Latch mode:** all channels are snapshotted together. A latch event copies every capture register and every accumulator into its holding register, then clears the accumulators. A latch event is either a zero-reached pulse from an external down-counter or a software strobe.

An optional no-overwrite rule stops the queue from losing data that has not been read. A flag-mode control can limit the channel flags to holding-register loads. The flags are driven out directly as interrupt requests.

Top module: `bic_top`

## Requirements
- R1: While reset is asserted, and right after it, the main counter, all capture, holding and accumulator registers, and all interrupt requests are zero.
- R2: The main counter increases by one on every clock and wraps from all ones to zero.
- R3: Each pin passes through two synchroniser flops. Edge selection per channel uses a two-bit code at bits [2i+1:2i]: 00 = disabled, 01 = rising, 10 = falling, 11 = both. A pin level first sampled at clock edge k produces its capture at edge k+2. The capture holds the counter value present just before edge k+2. A disabled channel neither captures nor counts.
- R4: With buffer enable 0, an edge loads only the capture register and sets the flag. The holding registers never change.
- R5: In queue mode (buffer enable 1, latch mode 0) with no-overwrite 0, an edge moves the capture value into the holding register and loads the counter into the capture register.
- R6: In latch mode (buffer enable 1, latch mode 1), a latch event copies all capture registers to their holding registers and all accumulators to their accumulator-holding registers. It then clears the accumulators. If an edge falls in the same cycle, that edge counts as 1. Edges in latch mode load only the capture register.
- R7: The zero-reached pulse and the software strobe have no effect unless latch mode is selected.
- R8: With saturate 0, an accumulator at 0xFF wraps to 0x00 on the next edge.
- R9: With saturate 1, an accumulator at 0xFF stays at 0xFF.
- R10: With flag mode 1 in queue mode, a flag is set only in a cycle where that channel's holding register is loaded. In every other case, flag mode 1 acts like flag mode 0: the flag is set on every capture.
- R11: No-overwrite in queue mode:
  - If the capture register is empty, an edge only loads the capture register.
  - If the capture register is full and the holding register is empty, an edge pushes the capture value into the holding register and captures.
  - If both registers are full, the edge changes neither register.
  - A hold-read strobe empties the holding register. Reset and latch transfers empty the capture register.
- R12: A 1 on a flag-clear bit clears that flag. A flag set and a clear in the same cycle leave the flag set. Each interrupt request equals its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NCH | Asynchronous capture pins |
| edge_sel | input | 2*NCH | Per-channel edge selection code |
| buf_en | input | 1 | Enables the holding registers |
| latch_mode | input | 1 | 0 = queue mode, 1 = latch mode |
| flag_mode | input | 1 | 1 = in queue mode, flag only on a holding-register load |
| no_ovw | input | 1 | No-overwrite rule for queue mode |
| pa_sat | input | 1 | Accumulator saturates at all ones |
| mod_zero | input | 1 | Zero-reached pulse from the down-counter |
| latch_strobe | input | 1 | Software latch strobe |
| flag_clr | input | NCH | Write-one-to-clear flag bits |
| hold_rd | input | NCH | Holding-register read strobes |
| timer_cnt | output | CW | Main counter value |
| capt_val | output | NCH*CW | Capture registers, channel i at [i*CW +: CW] |
| hold_val | output | NCH*CW | Capture holding registers |
| pacc_val | output | NCH*PW | Pulse accumulators |
| pacc_hold | output | NCH*PW | Accumulator holding registers |
| irq | output | NCH | Interrupt requests (channel flags) |

## Verification
Two kinds of event can fall in the same cycle.

- **Flag set and flag clear.** A flag-set edge can meet a flag-clear write. The bench sweeps the clear pulse across a range of cycle offsets after each pin toggle, so at some offset it lands exactly on the capture cycle.
- **Latch event and edge.** A latch event can meet a pin edge. The strobe and the zero-reached pulse are swept against the pin toggles in the same way.

In both cases a behavioural per-cycle model predicts the result: set wins over clear, and an accumulator restarts at 1 when a latch and an edge coincide. The bench compares every output against that model on every clock.

// File: rtl/bic_pkg.sv
package bic_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  // Qualifies a transition between the previous and current synchronised level.
  function automatic logic edge_hit(input logic [1:0] sel, input logic now, input logic prev);
    logic up, down;
    up   = now & ~prev;
    down = ~now & prev;
    case (edge_sel_e'(sel))
      EDGE_RISE: edge_hit = up;
      EDGE_FALL: edge_hit = down;
      EDGE_ANY:  edge_hit = up | down;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bic_sync_edge.sv
module bic_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       edge_o
);
  import bic_pkg::*;

  // STAGES synchroniser flops plus one history flop.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign edge_o = edge_hit(sel, sh[STAGES-1], sh[STAGES]);

endmodule

// File: rtl/bic_channel.sv
module bic_channel #(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_ev,
  input  logic [CW-1:0] cnt,
  input  logic          buf_en,
  input  logic          latch_mode,
  input  logic          flag_mode,
  input  logic          no_ovw,
  input  logic          pa_sat,
  input  logic          latch_ev,
  input  logic          flag_clr,
  input  logic          hold_rd,
  output logic [CW-1:0] cap_q,
  output logic [CW-1:0] hold_q,
  output logic [PW-1:0] pacc_q,
  output logic [PW-1:0] phold_q,
  output logic          flag_q,
  output logic          flag_set_o,
  output logic          hold_load_o
);

  // Accumulator step: hold at all ones when saturating, else wrap.
  function automatic logic [PW-1:0] pacc_step(input logic [PW-1:0] v, input logic sat);
    if (sat && (&v)) return v;
    return v + 1'b1;
  endfunction

  logic queue_on;
  logic cap_full, hold_full;
  logic do_cap, do_push;
  logic [PW-1:0] pacc_base;

  assign queue_on = buf_en & ~latch_mode;

  always_comb begin
    do_cap  = 1'b0;
    do_push = 1'b0;
    if (edge_ev) begin
      if (queue_on && no_ovw) begin
        if (!cap_full) begin
          do_cap = 1'b1;
        end else if (!hold_full) begin
          do_cap  = 1'b1;
          do_push = 1'b1;
        end
      end else if (queue_on) begin
        do_cap  = 1'b1;
        do_push = 1'b1;
      end else begin
        do_cap = 1'b1;
      end
    end
  end

  assign hold_load_o = do_push | latch_ev;
  assign flag_set_o  = do_cap & (~queue_on | ~flag_mode | do_push);
  assign pacc_base   = latch_ev ? '0 : pacc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q     <= '0;
      hold_q    <= '0;
      pacc_q    <= '0;
      phold_q   <= '0;
      flag_q    <= 1'b0;
      cap_full  <= 1'b0;
      hold_full <= 1'b0;
    end else begin
      if (do_cap)      cap_q   <= cnt;
      if (hold_load_o) hold_q  <= cap_q;
      if (latch_ev)    phold_q <= pacc_q;
      pacc_q <= edge_ev ? pacc_step(pacc_base, pa_sat) : pacc_base;
      flag_q <= flag_set_o | (flag_q & ~flag_clr);

      if (do_cap)        cap_full <= 1'b1;
      else if (latch_ev) cap_full <= 1'b0;

      if (hold_load_o)   hold_full <= 1'b1;
      else if (hold_rd)  hold_full <= 1'b0;
    end
  end

endmodule

// File: rtl/bic_top.sv
module bic_top #(
  parameter int NCH    = 4,
  parameter int CW     = 16,
  parameter int PW     = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_in,
  input  logic [2*NCH-1:0]  edge_sel,
  input  logic              buf_en,
  input  logic              latch_mode,
  input  logic              flag_mode,
  input  logic              no_ovw,
  input  logic              pa_sat,
  input  logic              mod_zero,
  input  logic              latch_strobe,
  input  logic [NCH-1:0]    flag_clr,
  input  logic [NCH-1:0]    hold_rd,
  output logic [CW-1:0]     timer_cnt,
  output logic [NCH*CW-1:0] capt_val,
  output logic [NCH*CW-1:0] hold_val,
  output logic [NCH*PW-1:0] pacc_val,
  output logic [NCH*PW-1:0] pacc_hold,
  output logic [NCH-1:0]    irq
);

  // Internal events, brought out for the checker.
  logic           latch_ev_w;
  logic [NCH-1:0] edge_w;
  logic [NCH-1:0] flag_set_w;
  logic [NCH-1:0] hold_load_w;

  assign latch_ev_w = buf_en & latch_mode & (mod_zero | latch_strobe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer_cnt <= '0;
    else        timer_cnt <= timer_cnt + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    bic_sync_edge #(.STAGES(STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (pin_in[i]),
      .sel    (edge_sel[2*i +: 2]),
      .edge_o (edge_w[i])
    );

    bic_channel #(.CW(CW), .PW(PW)) ch_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .edge_ev     (edge_w[i]),
      .cnt         (timer_cnt),
      .buf_en      (buf_en),
      .latch_mode  (latch_mode),
      .flag_mode   (flag_mode),
      .no_ovw      (no_ovw),
      .pa_sat      (pa_sat),
      .latch_ev    (latch_ev_w),
      .flag_clr    (flag_clr[i]),
      .hold_rd     (hold_rd[i]),
      .cap_q       (capt_val[i*CW +: CW]),
      .hold_q      (hold_val[i*CW +: CW]),
      .pacc_q      (pacc_val[i*PW +: PW]),
      .phold_q     (pacc_hold[i*PW +: PW]),
      .flag_q      (irq[i]),
      .flag_set_o  (flag_set_w[i]),
      .hold_load_o (hold_load_w[i])
    );
  end

endmodule

// File: rtl/bic_checker.sv
module bic_checker #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              buf_en,
  input logic              pa_sat,
  input logic [CW-1:0]     timer_cnt,
  input logic [NCH*CW-1:0] hold_val,
  input logic [NCH*PW-1:0] pacc_val,
  input logic [NCH-1:0]    irq,
  input logic              latch_ev_w,
  input logic [NCH-1:0]    flag_set_w
);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> timer_cnt == CW'($past(timer_cnt) + 1'b1));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_en |=> $stable(hold_val[i*CW +: CW]));

    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_sat && (&pacc_val[i*PW +: PW]) && !latch_ev_w) |=> (&pacc_val[i*PW +: PW]));

    a_r6_latch_clear: assert property (@(posedge clk) disable iff (!rst_n)
      latch_ev_w |=> pacc_val[i*PW +: PW] <= PW'(1));

    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set_w[i] |=> irq[i]);
  end

endmodule

bind bic_top bic_checker #(.NCH(NCH), .CW(CW), .PW(PW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .buf_en     (buf_en),
  .pa_sat     (pa_sat),
  .timer_cnt  (timer_cnt),
  .hold_val   (hold_val),
  .pacc_val   (pacc_val),
  .irq        (irq),
  .latch_ev_w (latch_ev_w),
  .flag_set_w (flag_set_w)
);

// File: tb/bic_top_tb_top.sv
`timescale 1ns/1ps
module bic_top_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int PW  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    pin_in = '0;
  logic [2*NCH-1:0]  edge_sel = '0;
  logic              buf_en = 1'b0, latch_mode = 1'b0, flag_mode = 1'b0;
  logic              no_ovw = 1'b0, pa_sat = 1'b0, mod_zero = 1'b0, latch_strobe = 1'b0;
  logic [NCH-1:0]    flag_clr = '0, hold_rd = '0;
  logic [CW-1:0]     timer_cnt;
  logic [NCH*CW-1:0] capt_val, hold_val;
  logic [NCH*PW-1:0] pacc_val, pacc_hold;
  logic [NCH-1:0]    irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bic_top dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_sel(edge_sel),
    .buf_en(buf_en), .latch_mode(latch_mode), .flag_mode(flag_mode),
    .no_ovw(no_ovw), .pa_sat(pa_sat), .mod_zero(mod_zero),
    .latch_strobe(latch_strobe), .flag_clr(flag_clr), .hold_rd(hold_rd),
    .timer_cnt(timer_cnt), .capt_val(capt_val), .hold_val(hold_val),
    .pacc_val(pacc_val), .pacc_hold(pacc_hold), .irq(irq)
  );

  // Behavioural reference model, one step per clock.
  int m_cnt;
  int m_cap[NCH], m_hold[NCH], m_pacc[NCH], m_phold[NCH];
  bit m_capf[NCH], m_holdf[NCH], m_flag[NCH];
  bit m_s1[NCH], m_s2[NCH], m_s3[NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      for (int c = 0; c < NCH; c++) begin
        m_cap[c] = 0; m_hold[c] = 0; m_pacc[c] = 0; m_phold[c] = 0;
        m_capf[c] = 0; m_holdf[c] = 0; m_flag[c] = 0;
        m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0;
      end
    end else begin
      bit lat;
      bit queue;
      lat   = buf_en && latch_mode && (mod_zero || latch_strobe);
      queue = buf_en && !latch_mode;
      for (int c = 0; c < NCH; c++) begin
        int sel;
        bit hit, took, pushed, fset;
        int old_cap, old_pacc;
        sel = int'(edge_sel[2*c +: 2]);
        hit = (m_s2[c] != m_s3[c]) &&
              ((sel == 3) || (sel == 1 && m_s2[c]) || (sel == 2 && !m_s2[c]));
        old_cap = m_cap[c]; old_pacc = m_pacc[c];
        took = 0; pushed = 0;
        if (hit) begin
          if (queue && no_ovw) begin
            if (!m_capf[c]) took = 1;
            else if (!m_holdf[c]) begin took = 1; pushed = 1; end
          end else begin
            took = 1; pushed = queue;
          end
        end
        if (lat) begin m_hold[c] = old_cap; m_phold[c] = old_pacc; m_pacc[c] = 0; end
        if (pushed) m_hold[c] = old_cap;
        if (took) m_cap[c] = m_cnt;
        if (hit) begin
          if (pa_sat && m_pacc[c] == 255) m_pacc[c] = 255;
          else m_pacc[c] = (m_pacc[c] + 1) % 256;
        end
        if (took) m_capf[c] = 1; else if (lat) m_capf[c] = 0;
        if (pushed || lat) m_holdf[c] = 1; else if (hold_rd[c]) m_holdf[c] = 0;
        fset = took && (!queue || !flag_mode || pushed);
        m_flag[c] = fset || (m_flag[c] && !flag_clr[c]);
      end
      for (int c = 0; c < NCH; c++) begin
        m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = pin_in[c];
      end
      m_cnt = (m_cnt + 1) % 65536;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 counter", int'(timer_cnt), m_cnt);
      for (int c = 0; c < NCH; c++) begin
        check("R3 capture", int'(capt_val[c*CW +: CW]), m_cap[c]);
        check("R5 hold", int'(hold_val[c*CW +: CW]), m_hold[c]);
        check("R8 accumulator", int'(pacc_val[c*PW +: PW]), m_pacc[c]);
        check("R6 accumulator hold", int'(pacc_hold[c*PW +: PW]), m_phold[c]);
        check("R12 irq", int'(irq[c]), int'(m_flag[c]));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin_in = '0; flag_clr = '0; hold_rd = '0; mod_zero = 0; latch_strobe = 0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic pulse_strobe(input bit use_zero);
    if (use_zero) mod_zero = 1; else latch_strobe = 1;
    cyc(1);
    mod_zero = 0; latch_strobe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int snap, snap2, snapp;
    // R1: reset state
    cyc(2);
    check("R1 counter", int'(timer_cnt), 0);
    check("R1 capture", int'(capt_val), 0);
    check("R1 hold", int'(hold_val), 0);
    check("R1 accumulators", int'(pacc_val) + int'(pacc_hold), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 counter after release", int'(timer_cnt), 1);

    // R4 / R3: unbuffered; ch0 rise, ch1 fall, ch2 both, ch3 off
    edge_sel = 8'b00_11_10_01;
    for (int k = 0; k < 6; k++) begin pin_in = ~pin_in; cyc(5); end
    check("R4 hold frozen", int'(hold_val), 0);
    check("R3 ch0 rising count", int'(pacc_val[0 +: 8]), 3);
    check("R3 ch1 falling count", int'(pacc_val[8 +: 8]), 3);
    check("R3 ch2 both count", int'(pacc_val[16 +: 8]), 6);
    check("R3 ch3 disabled", int'(pacc_val[24 +: 8]) + int'(capt_val[48 +: 16]), 0);
    // R12: clear swept against capture cycle
    for (int off = 0; off < 6; off++) begin
      pin_in = ~pin_in;
      cyc(off);
      flag_clr = '1; cyc(1); flag_clr = '0;
      cyc(4);
    end

    // R5: queue mode, no-overwrite off
    do_reset();
    buf_en = 1; latch_mode = 0; flag_mode = 0; no_ovw = 0;
    edge_sel = 8'b11_11_11_11;
    for (int k = 0; k < 4; k++) begin pin_in = pin_in ^ 4'(k + 1); cyc(4 + k); end
    snap = int'(capt_val[0 +: 16]);
    pin_in[0] = ~pin_in[0]; cyc(5);
    check("R5 push old capture", int'(hold_val[0 +: 16]), snap);

    // R10 / R11: queue, flag mode 1, no-overwrite on; ch0 rising only
    do_reset();
    flag_mode = 1; no_ovw = 1; edge_sel = 8'b00_00_00_01;
    cyc(2);
    pin_in[0] = 1; cyc(4); pin_in[0] = 0; cyc(3);
    check("R11 first edge hold untouched", int'(hold_val[0 +: 16]), 0);
    check("R10 no flag without hold load", int'(irq[0]), 0);
    snap = int'(capt_val[0 +: 16]);
    pin_in[0] = 1; cyc(4); pin_in[0] = 0; cyc(3);
    check("R11 second edge pushes", int'(hold_val[0 +: 16]), snap);
    check("R10 flag on hold load", int'(irq[0]), 1);
    snap2 = int'(capt_val[0 +: 16]);
    pin_in[0] = 1; cyc(4); pin_in[0] = 0; cyc(3);
    check("R11 full queue keeps capture", int'(capt_val[0 +: 16]), snap2);
    check("R11 full queue keeps hold", int'(hold_val[0 +: 16]), snap);
    hold_rd[0] = 1; cyc(1); hold_rd[0] = 0;
    pin_in[0] = 1; cyc(4); pin_in[0] = 0; cyc(3);
    check("R11 read frees hold", int'(hold_val[0 +: 16]), snap2);

    // R7: strobes ignored in queue mode
    no_ovw = 0; flag_mode = 0; edge_sel = 8'b11_11_11_11;
    pin_in = 4'hF; cyc(5);
    snapp = int'(pacc_val);
    pulse_strobe(0); pulse_strobe(1); cyc(2);
    check("R7 accumulators kept", int'(pacc_val), snapp);
    check("R7 accumulator hold kept", int'(pacc_hold), 0);

    // R6: latch mode, strobe and zero pulse swept against edges
    do_reset();
    buf_en = 1; latch_mode = 1; edge_sel = 8'b11_10_01_11;
    for (int k = 0; k < 3; k++) begin pin_in = ~pin_in; cyc(4); end
    snapp = int'(pacc_val[0 +: 8]);
    snap  = int'(capt_val[0 +: 16]);
    pulse_strobe(0); cyc(1);
    check("R6 accumulator copied", int'(pacc_hold[0 +: 8]), snapp);
    check("R6 capture copied", int'(hold_val[0 +: 16]), snap);
    check("R6 accumulator cleared", int'(pacc_val[0 +: 8]), 0);
    for (int off = 0; off < 6; off++) begin
      pin_in = ~pin_in;
      cyc(off);
      pulse_strobe(off[0]);
      cyc(4);
    end

    // R8: wrap with 256 edges
    do_reset();
    buf_en = 0; pa_sat = 0; edge_sel = 8'b00_11_00_00;
    for (int k = 0; k < 256; k++) begin pin_in[2] = ~pin_in[2]; cyc(1); end
    cyc(4);
    check("R8 wrap to zero", int'(pacc_val[16 +: 8]), 0);

    // R9: saturation with 300 edges
    do_reset();
    pa_sat = 1;
    for (int k = 0; k < 300; k++) begin pin_in[2] = ~pin_in[2]; cyc(1); end
    cyc(4);
    check("R9 saturated", int'(pacc_val[16 +: 8]), 255);

    cyc(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule